// File: doc/BRIEF.md
# Load/Store Address Check and Result Formatter

This block is the stage of a 64-bit core's load/store path that sits between the issue of a memory instruction and the memory itself. It receives a base register value, a 12-bit signed offset, the access width, a load/store flag, a sign/zero-extension flag and the store data. It forms the effective address, rejects misaligned accesses and splits the address into a 4 KiB page number and a slot index scaled by the access width. It then sends the access to a RAM window or a single device window, each set by parameters and rebased to that window's first page. On a load it returns the data extended to 64 bits. A faulting access yields a cause code and never commits.

The sequencing is a Moore state machine. Its states and transitions are:
- ST_IDLE: `req_valid` is taken here and the effective address is registered, going to ST_CHECK.
- ST_CHECK: a misaligned access or an unmapped page goes to ST_FAULT. A RAM page goes to ST_RAM. A device page goes to ST_DEV.
- ST_RAM: the RAM request is held until `ram_ack`, then the state goes to ST_DONE.
- ST_DEV: the device request is held until `dev_ack`. With `dev_err` the state goes to ST_FAULT, otherwise to ST_DONE.
- ST_DONE and ST_FAULT: each lasts one cycle and returns to ST_IDLE.

Top module: `ldst_check_top`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended to 64 bits, modulo 2^64.
- R2: Accesses of size half (1), word (2) or double (3) must be aligned to 2, 4 or 8 bytes. A misaligned load faults with cause 4 and a misaligned store faults with cause 6. Neither issues a memory request. Size encoding: 0 byte, 1 half, 2 word, 3 double.
- R3: A byte access (size 0) is never treated as misaligned.
- R4: The page is address bits 63:12. The slot is address bits 11:0 shifted right by the size code, so it is below 4096 >> size.
- R5: A page inside [RAM_BASE_PG, RAM_BASE_PG+RAM_PAGES) is sent to the RAM port with page minus RAM_BASE_PG.
- R6: Any other page inside [DEV_BASE_PG, DEV_BASE_PG+DEV_PAGES) is sent to the device port with page minus DEV_BASE_PG. Only one port is ever requested.
- R7: A page in neither window faults with cause 5 for a load and cause 7 for a store.
- R8: A load result is extended from bit 7, 15 or 31 of the returned data when `req_unsigned` is 0, and zero-extended when it is 1. A double load returns all 64 bits.
- R9: When the device answers with `dev_err`, `fault_cause` equals `dev_cause` unchanged.
- R10: In a faulting access `fault` pulses for one cycle. `done`, `rd_we` and `pc_adv` stay low throughout that access.
- R11: A successful access pulses `done` and `pc_adv` for one cycle. `rd_we` is high in that cycle for loads only.
- R12: Store data is driven out with the bits above the access width cleared.
- R13: The alignment check takes priority over the window lookup. A misaligned access to an unmapped page reports cause 4 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an access; taken only when not busy |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_unsigned | input | 1 | Zero-extend a narrow load |
| req_base | input | 64 | Base register value |
| req_imm | input | 12 | Signed offset |
| req_wdata | input | 64 | Store data |
| busy | output | 1 | An access is in progress |
| ram_req | output | 1 | RAM access request, held until ack |
| ram_we | output | 1 | RAM write |
| ram_size | output | 2 | RAM access size code |
| ram_page | output | 52 | Page rebased to the RAM window |
| ram_slot | output | 12 | Size-scaled slot within the page |
| ram_wdata | output | 64 | Truncated store data |
| ram_ack | input | 1 | RAM response valid |
| ram_rdata | input | 64 | RAM read data, element in low bits |
| dev_req | output | 1 | Device access request, held until ack |
| dev_we | output | 1 | Device write |
| dev_size | output | 2 | Device access size code |
| dev_page | output | 52 | Page rebased to the device window |
| dev_slot | output | 12 | Size-scaled slot within the page |
| dev_wdata | output | 64 | Truncated store data |
| dev_ack | input | 1 | Device response valid |
| dev_err | input | 1 | Device refused the access |
| dev_cause | input | 5 | Device-supplied cause code |
| dev_rdata | input | 64 | Device read data, element in low bits |
| done | output | 1 | Access completed without fault |
| pc_adv | output | 1 | Program counter may advance |
| rd_we | output | 1 | Destination register write enable |
| ld_data | output | 64 | Formatted load result |
| fault | output | 1 | Access faulted |
| fault_cause | output | 5 | Fault cause code |

## Verification
The hardest cases to reach from the ports are those where two checks compete: a misaligned address that also lies in no window, where alignment must win. Others sit on a window edge, either the last RAM page or the first page beyond it. These need base and offset pairs chosen together, because random 64-bit bases almost never land in a window. The stimulus first picks a target address inside RAM, the device window or the hole between them. It may then nudge that address off alignment, and finally picks a random offset and derives the base from it. The offset sign and the 64-bit wrap are therefore exercised on every vector. The device responder refuses every access to its last page, which produces the pass-through cause path.

// File: rtl/ldst_chk_pkg.sv
package ldst_chk_pkg;
    localparam int ADDR_W   = 64;
    localparam int OFS_W    = 12;
    localparam int PAGE_W   = ADDR_W - OFS_W;
    localparam int IMM_W    = 12;
    localparam int CAUSE_W  = 5;

    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } acc_size_e;

    localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = 5'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_ACCESS   = 5'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = 5'd6;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_ACCESS   = 5'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RAM,
        ST_DEV,
        ST_DONE,
        ST_FAULT
    } ldst_state_e;
endpackage

// File: rtl/ldst_addr_split.sv
module ldst_addr_split
    import ldst_chk_pkg::*;
(
    input  logic [ADDR_W-1:0] ea,
    input  acc_size_e         size,
    output page_t             page,
    output logic [OFS_W-1:0]  slot,
    output logic              misaligned
);
    logic [2:0] low_mask;

    always_comb begin
        unique case (size)
            SZ_BYTE:   low_mask = 3'b000;
            SZ_HALF:   low_mask = 3'b001;
            SZ_WORD:   low_mask = 3'b011;
            SZ_DOUBLE: low_mask = 3'b111;
            default:   low_mask = 3'b000;
        endcase
    end

    assign misaligned = |(ea[2:0] & low_mask);
    assign page       = ea[ADDR_W-1:OFS_W];
    assign slot       = ea[OFS_W-1:0] >> size;
endmodule

// File: rtl/ldst_range_hit.sv
module ldst_range_hit
    import ldst_chk_pkg::*;
#(
    parameter page_t FIRST_PG = '0,
    parameter page_t NUM_PG   = page_t'(1)
) (
    input  page_t page,
    output logic  hit,
    output page_t rel_page
);
    assign rel_page = page - FIRST_PG;
    assign hit      = (page >= FIRST_PG) && (rel_page < NUM_PG);
endmodule

// File: rtl/ldst_data_fmt.sv
module ldst_data_fmt
    import ldst_chk_pkg::*;
(
    input  acc_size_e         size,
    input  logic              zero_ext,
    input  logic [ADDR_W-1:0] rdata,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] ld_val,
    output logic [ADDR_W-1:0] st_val
);
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                ld_val = zero_ext ? {56'd0, rdata[7:0]}
                                  : {{56{rdata[7]}}, rdata[7:0]};
                st_val = {56'd0, wdata[7:0]};
            end
            SZ_HALF: begin
                ld_val = zero_ext ? {48'd0, rdata[15:0]}
                                  : {{48{rdata[15]}}, rdata[15:0]};
                st_val = {48'd0, wdata[15:0]};
            end
            SZ_WORD: begin
                ld_val = zero_ext ? {32'd0, rdata[31:0]}
                                  : {{32{rdata[31]}}, rdata[31:0]};
                st_val = {32'd0, wdata[31:0]};
            end
            default: begin
                ld_val = rdata;
                st_val = wdata;
            end
        endcase
    end
endmodule

// File: rtl/ldst_check_top.sv
module ldst_check_top
    import ldst_chk_pkg::*;
#(
    parameter page_t RAM_BASE_PG = page_t'(52'h80000),
    parameter page_t RAM_PAGES   = page_t'(256),
    parameter page_t DEV_BASE_PG = page_t'(52'h10000),
    parameter page_t DEV_PAGES   = page_t'(4)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic                req_unsigned,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [IMM_W-1:0]    req_imm,
    input  logic [ADDR_W-1:0]   req_wdata,
    output logic                busy,
    output logic                ram_req,
    output logic                ram_we,
    output logic [1:0]          ram_size,
    output logic [PAGE_W-1:0]   ram_page,
    output logic [OFS_W-1:0]    ram_slot,
    output logic [ADDR_W-1:0]   ram_wdata,
    input  logic                ram_ack,
    input  logic [ADDR_W-1:0]   ram_rdata,
    output logic                dev_req,
    output logic                dev_we,
    output logic [1:0]          dev_size,
    output logic [PAGE_W-1:0]   dev_page,
    output logic [OFS_W-1:0]    dev_slot,
    output logic [ADDR_W-1:0]   dev_wdata,
    input  logic                dev_ack,
    input  logic                dev_err,
    input  logic [CAUSE_W-1:0]  dev_cause,
    input  logic [ADDR_W-1:0]   dev_rdata,
    output logic                done,
    output logic                pc_adv,
    output logic                rd_we,
    output logic [ADDR_W-1:0]   ld_data,
    output logic                fault,
    output logic [CAUSE_W-1:0]  fault_cause
);
    ldst_state_e state_q, state_d;

    logic [ADDR_W-1:0]  ea_q;
    acc_size_e          size_q;
    logic               store_q;
    logic               zext_q;
    logic [ADDR_W-1:0]  wdata_q;
    logic [ADDR_W-1:0]  rdata_q;
    logic [CAUSE_W-1:0] cause_q;
    page_t              tgt_page_q;
    logic [OFS_W-1:0]   tgt_slot_q;

    logic [ADDR_W-1:0]  ea_sum;
    page_t              split_page;
    logic [OFS_W-1:0]   split_slot;
    logic               split_misal;
    logic               ram_hit, dev_hit;
    page_t              ram_rel, dev_rel;
    logic [ADDR_W-1:0]  fmt_ld, fmt_st;

    assign ea_sum = req_base + {{(ADDR_W-IMM_W){req_imm[IMM_W-1]}}, req_imm};

    ldst_addr_split u_split (
        .ea         (ea_q),
        .size       (size_q),
        .page       (split_page),
        .slot       (split_slot),
        .misaligned (split_misal)
    );

    ldst_range_hit #(.FIRST_PG(RAM_BASE_PG), .NUM_PG(RAM_PAGES)) u_ram_win (
        .page     (split_page),
        .hit      (ram_hit),
        .rel_page (ram_rel)
    );

    ldst_range_hit #(.FIRST_PG(DEV_BASE_PG), .NUM_PG(DEV_PAGES)) u_dev_win (
        .page     (split_page),
        .hit      (dev_hit),
        .rel_page (dev_rel)
    );

    ldst_data_fmt u_fmt (
        .size     (size_q),
        .zero_ext (zext_q),
        .rdata    (rdata_q),
        .wdata    (wdata_q),
        .ld_val   (fmt_ld),
        .st_val   (fmt_st)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (split_misal)  state_d = ST_FAULT;
                else if (ram_hit) state_d = ST_RAM;
                else if (dev_hit) state_d = ST_DEV;
                else              state_d = ST_FAULT;
            end
            ST_RAM:   if (ram_ack) state_d = ST_DONE;
            ST_DEV:   if (dev_ack) state_d = dev_err ? ST_FAULT : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q       <= '0;
            size_q     <= SZ_BYTE;
            store_q    <= 1'b0;
            zext_q     <= 1'b0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            cause_q    <= '0;
            tgt_page_q <= '0;
            tgt_slot_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ea_q    <= ea_sum;
                        size_q  <= acc_size_e'(req_size);
                        store_q <= req_store;
                        zext_q  <= req_unsigned;
                        wdata_q <= req_wdata;
                    end
                end
                ST_CHECK: begin
                    tgt_slot_q <= split_slot;
                    tgt_page_q <= ram_hit ? ram_rel : dev_rel;
                    if (split_misal)
                        cause_q <= store_q ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
                    else if (!ram_hit && !dev_hit)
                        cause_q <= store_q ? CAUSE_ST_ACCESS : CAUSE_LD_ACCESS;
                end
                ST_RAM: begin
                    if (ram_ack) rdata_q <= ram_rdata;
                end
                ST_DEV: begin
                    if (dev_ack) begin
                        rdata_q <= dev_rdata;
                        if (dev_err) cause_q <= dev_cause;
                    end
                end
                default: ;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        busy        = 1'b1;
        ram_req     = 1'b0;
        dev_req     = 1'b0;
        ram_we      = 1'b0;
        dev_we      = 1'b0;
        ram_size    = size_q;
        dev_size    = size_q;
        ram_page    = '0;
        dev_page    = '0;
        ram_slot    = '0;
        dev_slot    = '0;
        ram_wdata   = '0;
        dev_wdata   = '0;
        done        = 1'b0;
        pc_adv      = 1'b0;
        rd_we       = 1'b0;
        ld_data     = '0;
        fault       = 1'b0;
        fault_cause = '0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_CHECK: ;
            ST_RAM: begin
                ram_req   = 1'b1;
                ram_we    = store_q;
                ram_page  = tgt_page_q;
                ram_slot  = tgt_slot_q;
                ram_wdata = store_q ? fmt_st : '0;
            end
            ST_DEV: begin
                dev_req   = 1'b1;
                dev_we    = store_q;
                dev_page  = tgt_page_q;
                dev_slot  = tgt_slot_q;
                dev_wdata = store_q ? fmt_st : '0;
            end
            ST_DONE: begin
                done    = 1'b1;
                pc_adv  = 1'b1;
                rd_we   = !store_q;
                ld_data = store_q ? '0 : fmt_ld;
            end
            ST_FAULT: begin
                fault       = 1'b1;
                fault_cause = cause_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ldst_check_sva.sv
module ldst_check_sva
    import ldst_chk_pkg::*;
#(
    parameter page_t RAM_PAGES = page_t'(256),
    parameter page_t DEV_PAGES = page_t'(4)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_req,
    input logic              ram_we,
    input logic [1:0]        ram_size,
    input logic [PAGE_W-1:0] ram_page,
    input logic [OFS_W-1:0]  ram_slot,
    input logic [ADDR_W-1:0] ram_wdata,
    input logic              ram_ack,
    input logic              dev_req,
    input logic [PAGE_W-1:0] dev_page,
    input logic              done,
    input logic              pc_adv,
    input logic              rd_we,
    input logic              fault
);
    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R10
    AST_FAULT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!rd_we && !pc_adv)); // R10
    AST_PCADV_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |-> done); // R11
    AST_RDWE_WITH_PCADV: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> pc_adv); // R11
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_req && dev_req)); // R6
    AST_RAM_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> (page_t'(ram_page) < RAM_PAGES)); // R5
    AST_DEV_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req |-> (page_t'(dev_page) < DEV_PAGES)); // R6
    AST_SLOT_SCALED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> ({1'b0, ram_slot} < (13'd4096 >> ram_size))); // R4
    AST_BYTE_STORE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && ram_we && ram_size == 2'd0) |-> (ram_wdata[63:8] == '0)); // R12
    AST_RAM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_ack) |=> (ram_req && $stable(ram_page) && $stable(ram_slot))); // R5
endmodule

bind ldst_check_top ldst_check_sva #(
    .RAM_PAGES(RAM_PAGES),
    .DEV_PAGES(DEV_PAGES)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_req   (ram_req),
    .ram_we    (ram_we),
    .ram_size  (ram_size),
    .ram_page  (ram_page),
    .ram_slot  (ram_slot),
    .ram_wdata (ram_wdata),
    .ram_ack   (ram_ack),
    .dev_req   (dev_req),
    .dev_page  (dev_page),
    .done      (done),
    .pc_adv    (pc_adv),
    .rd_we     (rd_we),
    .fault     (fault)
);

// File: tb/ldst_check_top_tb_top.sv
module ldst_check_top_tb_top;
    localparam logic [63:0] RAM_ADDR  = 64'h8000_0000;
    localparam logic [63:0] RAM_NPG   = 64'd256;
    localparam logic [63:0] DEV_ADDR  = 64'h1000_0000;
    localparam logic [63:0] DEV_NPG   = 64'd4;
    localparam logic [63:0] HOLE_ADDR = 64'h2000_0000;
    localparam logic [4:0]  DEV_BAD_CAUSE = 5'd19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_store = 0, req_unsigned = 0;
    logic [1:0]  req_size = 0;
    logic [63:0] req_base = 0, req_wdata = 0;
    logic [11:0] req_imm = 0;
    logic        busy;
    logic        ram_req, ram_we;
    logic [1:0]  ram_size;
    logic [51:0] ram_page;
    logic [11:0] ram_slot;
    logic [63:0] ram_wdata;
    logic        ram_ack = 0;
    logic [63:0] ram_rdata = 0;
    logic        dev_req, dev_we;
    logic [1:0]  dev_size;
    logic [51:0] dev_page;
    logic [11:0] dev_slot;
    logic [63:0] dev_wdata;
    logic        dev_ack = 0, dev_err = 0;
    logic [4:0]  dev_cause = 0;
    logic [63:0] dev_rdata = 0;
    logic        done, pc_adv, rd_we, fault;
    logic [63:0] ld_data;
    logic [4:0]  fault_cause;

    ldst_check_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_imm(req_imm), .req_wdata(req_wdata), .busy(busy),
        .ram_req(ram_req), .ram_we(ram_we), .ram_size(ram_size), .ram_page(ram_page),
        .ram_slot(ram_slot), .ram_wdata(ram_wdata), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
        .dev_req(dev_req), .dev_we(dev_we), .dev_size(dev_size), .dev_page(dev_page),
        .dev_slot(dev_slot), .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_err(dev_err),
        .dev_cause(dev_cause), .dev_rdata(dev_rdata), .done(done), .pc_adv(pc_adv),
        .rd_we(rd_we), .ld_data(ld_data), .fault(fault), .fault_cause(fault_cause)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic        seen_ram, seen_dev, cap_we;
    logic [51:0] cap_page;
    logic [11:0] cap_slot;
    logic [63:0] cap_wdata;

    function automatic logic [63:0] mem_val(input logic [7:0] tag, input logic [51:0] pg,
                                            input logic [11:0] sl);
        logic [31:0] h;
        h = (pg[31:0] * 32'h9E3779B1) ^ ({20'd0, sl} * 32'h85EBCA6B) ^ {24'd0, tag};
        return {h ^ 32'h5BD1E995, h};
    endfunction

    function automatic logic [63:0] fmt_ld(input logic [63:0] v, input logic [1:0] sz,
                                           input logic uns);
        case (sz)
            2'd0: return uns ? {56'd0, v[7:0]}  : {{56{v[7]}}, v[7:0]};
            2'd1: return uns ? {48'd0, v[15:0]} : {{48{v[15]}}, v[15:0]};
            2'd2: return uns ? {32'd0, v[31:0]} : {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] trunc(input logic [63:0] v, input logic [1:0] sz);
        case (sz)
            2'd0: return {56'd0, v[7:0]};
            2'd1: return {48'd0, v[15:0]};
            2'd2: return {32'd0, v[31:0]};
            default: return v;
        endcase
    endfunction

    // RAM and device responders
    always @(negedge clk) begin
        if (ram_req && !ram_ack) begin
            ram_ack   <= 1'b1;
            ram_rdata <= mem_val(8'h11, ram_page, ram_slot);
            seen_ram  <= 1'b1;
            cap_page  <= ram_page;
            cap_slot  <= ram_slot;
            cap_we    <= ram_we;
            cap_wdata <= ram_wdata;
        end else begin
            ram_ack <= 1'b0;
        end
        if (dev_req && !dev_ack) begin
            dev_ack   <= 1'b1;
            dev_rdata <= mem_val(8'h77, dev_page, dev_slot);
            dev_err   <= (dev_page == 52'(DEV_NPG - 1));
            dev_cause <= (dev_page == 52'(DEV_NPG - 1)) ? DEV_BAD_CAUSE : 5'd0;
            seen_dev  <= 1'b1;
            cap_page  <= dev_page;
            cap_slot  <= dev_slot;
            cap_we    <= dev_we;
            cap_wdata <= dev_wdata;
        end else begin
            dev_ack <= 1'b0;
            dev_err <= 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_access(input logic [63:0] base, input logic [11:0] imm,
                             input logic st, input logic [1:0] sz, input logic uns,
                             input logic [63:0] wd);
        logic [63:0] ea, ld_exp;
        logic [51:0] pg, rel;
        logic [11:0] sl;
        logic        misal, in_ram, in_dev, exp_fault;
        logic [4:0]  exp_cause;
        logic        got_any;
        // R1: effective address with wrap-around
        ea = base + {{52{imm[11]}}, imm};
        pg = ea[63:12];
        sl = ea[11:0] >> sz;
        misal  = (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 0) ||
                 (sz == 2'd3 && ea[2:0] != 0);
        in_ram = ({12'd0, pg} >= RAM_ADDR[63:12]) && ({12'd0, pg} < RAM_ADDR[63:12] + RAM_NPG);
        in_dev = !in_ram && ({12'd0, pg} >= DEV_ADDR[63:12]) &&
                 ({12'd0, pg} < DEV_ADDR[63:12] + DEV_NPG);
        rel = in_ram ? pg - RAM_ADDR[63:12] : pg - DEV_ADDR[63:12];
        exp_fault = 1'b0;
        exp_cause = 5'd0;
        if (misal) begin
            exp_fault = 1'b1; exp_cause = st ? 5'd6 : 5'd4;
        end else if (!in_ram && !in_dev) begin
            exp_fault = 1'b1; exp_cause = st ? 5'd7 : 5'd5;
        end else if (in_dev && rel == 52'(DEV_NPG - 1)) begin
            exp_fault = 1'b1; exp_cause = DEV_BAD_CAUSE;
        end
        ld_exp = fmt_ld(mem_val(in_ram ? 8'h11 : 8'h77, rel, sl), sz, uns);

        @(negedge clk);
        seen_ram = 1'b0; seen_dev = 1'b0;
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
        req_base = base; req_imm = imm; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got_any = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done || fault) begin got_any = 1'b1; break; end
            if (rd_we || pc_adv) chk("R10", "early commit", {62'd0, rd_we, pc_adv}, 64'd0);
            @(negedge clk);
        end
        chk("R11", "completion", {63'd0, got_any}, 64'd1);
        if (exp_fault) begin
            chk(misal ? "R2" : (in_dev ? "R9" : "R7"), "fault", {63'd0, fault}, 64'd1);
            chk(misal ? "R2" : (in_dev ? "R9" : "R7"), "cause", {59'd0, fault_cause},
                {59'd0, exp_cause});
            chk("R10", "commit on fault", {61'd0, done, rd_we, pc_adv}, 64'd0);
            chk("R2", "request on precheck fault", {62'd0, seen_ram, seen_dev},
                (misal || !in_dev) ? 64'd0 : 64'd1);
        end else begin
            chk("R11", "done/pc_adv", {62'd0, done, pc_adv}, 64'd3);
            chk("R11", "rd_we", {63'd0, rd_we}, {63'd0, !st});
            chk(in_ram ? "R5" : "R6", "target", {62'd0, seen_ram, seen_dev},
                in_ram ? 64'd2 : 64'd1);
            chk(in_ram ? "R5" : "R6", "rebased page", {12'd0, cap_page}, {12'd0, rel});
            chk("R4", "slot", {52'd0, cap_slot}, {52'd0, sl});
            if (st) chk("R12", "store data", cap_wdata, trunc(wd, sz));
            else    chk("R8", "load data", ld_data, ld_exp);
        end
        @(negedge clk);
    endtask

    function automatic logic [63:0] pick_target(input int kind, input logic [1:0] sz);
        logic [63:0] a;
        case (kind)
            0, 1: a = RAM_ADDR + 64'($urandom_range(0, 32'(RAM_NPG * 4096) - 1));
            2:    a = DEV_ADDR + 64'($urandom_range(0, 32'(DEV_NPG * 4096) - 1));
            default: a = HOLE_ADDR + 64'($urandom_range(0, 32'h00FF_FFFF));
        endcase
        a = a & ~((64'd1 << sz) - 1);
        return a;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // reset state
        chk("R11", "reset outputs", {58'd0, busy, ram_req, dev_req, done, fault, pc_adv}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle outputs", {60'd0, done, fault, rd_we, pc_adv}, 64'd0);

        // R1: negative offset reaching RAM base
        do_access(RAM_ADDR + 64'd4, 12'hFFC, 1'b0, 2'd2, 1'b0, 64'd0);
        // R1: wrap-around of base plus offset lands in unmapped space
        do_access(64'hFFFF_FFFF_FFFF_FFF0, 12'h020, 1'b0, 2'd3, 1'b0, 64'd0);
        // R3: byte access at odd address succeeds
        do_access(RAM_ADDR + 64'd1, 12'h002, 1'b0, 2'd0, 1'b0, 64'd0);
        // R2: misaligned double store, misaligned half load
        do_access(RAM_ADDR, 12'h004, 1'b1, 2'd3, 1'b0, 64'h1234);
        do_access(RAM_ADDR, 12'h001, 1'b0, 2'd1, 1'b0, 64'd0);
        // R13: misaligned and unmapped reports misalignment
        do_access(HOLE_ADDR, 12'h002, 1'b1, 2'd2, 1'b0, 64'd0);
        do_access(HOLE_ADDR, 12'h002, 1'b0, 2'd2, 1'b0, 64'd0);
        // R5/R7: last RAM page and first page past it
        do_access(RAM_ADDR + RAM_NPG * 4096 - 8, 12'h000, 1'b0, 2'd3, 1'b0, 64'd0);
        do_access(RAM_ADDR + RAM_NPG * 4096, 12'h000, 1'b1, 2'd0, 1'b0, 64'hFF);
        // R9: device error pass-through
        do_access(DEV_ADDR + (DEV_NPG - 1) * 4096, 12'h010, 1'b0, 2'd2, 1'b0, 64'd0);
        // R8: unsigned vs signed byte from same place
        do_access(DEV_ADDR, 12'h003, 1'b0, 2'd0, 1'b1, 64'd0);
        do_access(DEV_ADDR, 12'h003, 1'b0, 2'd0, 1'b0, 64'd0);
        // R12: word store with upper bits set
        do_access(RAM_ADDR, 12'h7FC, 1'b1, 2'd2, 1'b0, 64'hDEAD_BEEF_CAFE_F00D);

        for (int v = 0; v < 400; v++) begin
            logic [1:0]  sz;
            logic [63:0] tgt;
            logic [11:0] imm;
            sz  = 2'($urandom_range(0, 3));
            tgt = pick_target($urandom_range(0, 3), sz);
            if ($urandom_range(0, 4) == 0 && sz != 2'd0) tgt = tgt + 64'd1;
            imm = 12'($urandom);
            do_access(tgt - {{52{imm[11]}}, imm}, imm, 1'($urandom), sz, 1'($urandom),
                      {$urandom, $urandom});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule